// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks the element indices of one vector operation, from 0 upward, one index per clock, after a start pulse. For every index it gives a verdict: the element executes and its result is stored, it is skipped, or it is written as zero. The verdict combines a predicate bit with the operation's mode. The predicate comes either from an integer mask register or from one bit of a per-element condition field. The code that selects it is a 3-bit selector plus a one-bit source kind.

Two modes stop the walk early. In condition-driven early exit, the current element's result condition field is tested. The first enabled element that fails ends the vector, and the vector length becomes that element's index, which may be zero. In memory-driven early exit, a fault on element 0 is reported as a fault. A fault on a later enabled element shortens the vector length to that index instead. A third mode, result-gated store, writes each enabled element's condition field but cancels the data store when the test fails. The execution unit, the register files and the fault sources sit outside. They present their values on plain input ports: mask registers and predicate condition fields stay stable for the whole operation, and the current element's result field and fault flag follow `elem_idx`.

The controller is a three-state machine. IDLE moves to RUN on `start` when the requested length is non-zero (transition GO), or straight to DONE when it is zero (transition EMPTY). RUN stays in RUN while elements remain (transition STEP). RUN moves to DONE after the last element (transition FINISH) or on an early stop (transition CUT). DONE returns to IDLE after one cycle (transition RELEASE).

Top module: `vec_elem_seq`

## Requirements
- R1: With `mask_kind`=0, `pred_sel`=000 enables every element, and `pred_sel`=001 enables only the element whose index equals the full value of `r3` (no element if `r3` is not smaller than the length).
- R2: With `mask_kind`=0, `pred_sel`[2:1] chooses the mask register (01 `r3`, 10 `r10`, 11 `r30`), and element i is enabled when bit i of that register is 1 (`pred_sel`[0]=0) or 0 (`pred_sel`[0]=1).
- R3: With `mask_kind`=1, element i uses the 4-bit field `pred_cr`[4i+3:4i], whose bits 3,2,1,0 are LT, GT, EQ, SO. `pred_sel`[2:1] picks LT=00, GT=01, EQ=10, SO=11, and `pred_sel`[0]=0 enables when the bit is set and 1 enables when it is clear.
- R4: A predicate-disabled element never asserts `elem_en` or `cr_write`. It asserts `elem_zero` when `zero_en` is 1 and is skipped otherwise. `elem_en` and `elem_zero` are never high together.
- R5: In `mode_sel`=01 (condition early exit), each enabled element tests bit `res_cr`[3-`test_sel`] (same LT/GT/EQ/SO order). The test passes when that bit differs from `test_inv`. The first failing enabled element and all later elements are discarded, and `vl_out` becomes its index. Disabled elements are not tested. `cr_write` equals `rc_en` for passing enabled elements.
- R6: In condition early exit, a failure on element 0 yields `vl_out`=0 with no element enabled.
- R7: In `mode_sel`=10 (memory early exit), `ld_fault` on enabled element 0 pulses `fault_report`, discards the vector and keeps `vl_out` at the requested length. A fault on a later enabled element truncates `vl_out` to its index, so the result is never 0. Faults on disabled elements are ignored.
- R8: In `mode_sel`=11 (result-gated store), every enabled element asserts `cr_write` when `rc_en`=1. `elem_en` is asserted only when the R5 test passes. With `zero_en`=1, elements that are disabled or fail the test assert `elem_zero`.
- R9: Elements are presented in strictly ascending order, one per clock, with `elem_valid` high. `done` pulses for one cycle, one cycle after the last element or the early stop. A length of 0 gives `done` one cycle after `start` with no element, and lengths above MAX_VL are clamped.
- R10: `mask_kind`=0, `pred_sel`=000, `zero_en`=0, `mode_sel`=00, `rc_en`=0 and length 1 enable exactly element 0 and return `vl_out`=1, as for a non-vector operation.
- R11: After reset, `done`, `elem_valid` and all per-element outputs are 0 and `vl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| vl_in | input | VLW | Requested vector length |
| mask_kind | input | 1 | Predicate source: 0 integer, 1 condition field |
| pred_sel | input | 3 | Predicate selector code |
| zero_en | input | 1 | Zero disabled or rejected elements instead of skipping |
| mode_sel | input | 2 | 00 plain, 01 condition early exit, 10 memory early exit, 11 result-gated store |
| test_sel | input | 2 | Result condition bit to test (LT, GT, EQ, SO) |
| test_inv | input | 1 | Invert the result test |
| rc_en | input | 1 | Condition field write enable of the operation |
| r3 | input | XLEN | First integer mask register |
| r10 | input | XLEN | Second integer mask register |
| r30 | input | XLEN | Third integer mask register |
| pred_cr | input | 4*MAX_VL | Predicate condition fields, field i for element i |
| res_cr | input | 4 | Result condition field of the current element |
| ld_fault | input | 1 | Memory fault of the current element |
| elem_valid | output | 1 | An element slot is presented this cycle |
| elem_idx | output | IW | Index of the presented element |
| elem_en | output | 1 | Store the element's result |
| elem_zero | output | 1 | Store zero for the element |
| cr_write | output | 1 | Write the element's condition field |
| fault_report | output | 1 | Element 0 memory fault to be reported |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Final vector length |

## Verification
The two functions that can fall in the same cycle are the natural end of the walk and an early stop. When the last element fails its condition test, or faults in memory early exit, both want to end RUN. The bench provokes this with a failing pattern or a fault on element VL-1. It expects `vl_out`=VL-1, the element discarded, and `done` arriving at the same cycle as a normal finish. The bench also times `done` against `start` for full, truncated and empty vectors, and checks each verdict mask element by element.

// File: rtl/vec_elem_seq_pkg.sv
package vec_elem_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_PLAIN = 2'd0,
        MD_CRFF  = 2'd1,
        MD_LDFF  = 2'd2,
        MD_PRES  = 2'd3
    } seq_mode_e;

    // bit position of a condition flag inside a 4-bit field (LT at the top)
    function automatic logic cr_flag(input logic [3:0] fld, input logic [1:0] which);
        logic b;
        unique case (which)
            2'd0: b = fld[3];
            2'd1: b = fld[2];
            2'd2: b = fld[1];
            default: b = fld[0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vec_pred_gen.sv
module vec_pred_gen
    import vec_elem_seq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 16,
    parameter int IW     = 4
) (
    input  logic                  mask_kind,
    input  logic [2:0]            pred_sel,
    input  logic [IW-1:0]         idx,
    input  logic [XLEN-1:0]       r3,
    input  logic [XLEN-1:0]       r10,
    input  logic [XLEN-1:0]       r30,
    input  logic [4*MAX_VL-1:0]   pred_cr,
    output logic                  pred_bit
);
    localparam int XIW = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam int FIW = $clog2(4 * MAX_VL);

    logic [XIW-1:0] bit_pos;
    logic [FIW-1:0] fld_pos;
    logic [3:0]     fld;
    logic           int_bit;
    logic           cr_bit;

    always_comb begin
        bit_pos = XIW'(idx);
        fld_pos = FIW'({idx, 2'b00});
        fld     = pred_cr[fld_pos +: 4];
        cr_bit  = cr_flag(fld, pred_sel[2:1]) ^ pred_sel[0];
        unique case (pred_sel[2:1])
            2'b00:   int_bit = pred_sel[0] ? (r3 == XLEN'(idx)) : 1'b1;
            2'b01:   int_bit = r3[bit_pos]  ^ pred_sel[0];
            2'b10:   int_bit = r10[bit_pos] ^ pred_sel[0];
            default: int_bit = r30[bit_pos] ^ pred_sel[0];
        endcase
        pred_bit = mask_kind ? cr_bit : int_bit;
    end

endmodule

// File: rtl/vec_elem_decide.sv
module vec_elem_decide
    import vec_elem_seq_pkg::*;
(
    input  logic       active,
    input  seq_mode_e  mode,
    input  logic       pred_bit,
    input  logic [3:0] res_cr,
    input  logic [1:0] test_sel,
    input  logic       test_inv,
    input  logic       ld_fault,
    input  logic       zero_en,
    input  logic       rc_en,
    input  logic       idx_zero,
    output logic       en,
    output logic       zero,
    output logic       crw,
    output logic       stop,
    output logic       fault_rep
);
    logic pass;

    always_comb begin
        pass      = cr_flag(res_cr, test_sel) ^ test_inv;
        en        = pred_bit;
        zero      = zero_en & ~pred_bit;
        crw       = rc_en & pred_bit;
        stop      = 1'b0;
        fault_rep = 1'b0;
        unique case (mode)
            MD_CRFF: begin
                if (pred_bit && !pass) begin
                    en   = 1'b0;
                    zero = 1'b0;
                    crw  = 1'b0;
                    stop = 1'b1;
                end
            end
            MD_LDFF: begin
                if (pred_bit && ld_fault) begin
                    en        = 1'b0;
                    zero      = 1'b0;
                    crw       = 1'b0;
                    stop      = 1'b1;
                    fault_rep = idx_zero;
                end
            end
            MD_PRES: begin
                en   = pred_bit & pass;
                zero = zero_en & ~(pred_bit & pass);
                crw  = rc_en & pred_bit;
            end
            default: ;
        endcase
        if (!active) begin
            en        = 1'b0;
            zero      = 1'b0;
            crw       = 1'b0;
            stop      = 1'b0;
            fault_rep = 1'b0;
        end
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vec_elem_seq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 16,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VLW-1:0]      vl_in,
    input  logic                mask_kind,
    input  logic [2:0]          pred_sel,
    input  logic                zero_en,
    input  logic [1:0]          mode_sel,
    input  logic [1:0]          test_sel,
    input  logic                test_inv,
    input  logic                rc_en,
    input  logic [XLEN-1:0]     r3,
    input  logic [XLEN-1:0]     r10,
    input  logic [XLEN-1:0]     r30,
    input  logic [4*MAX_VL-1:0] pred_cr,
    input  logic [3:0]          res_cr,
    input  logic                ld_fault,
    output logic                elem_valid,
    output logic [IW-1:0]       elem_idx,
    output logic                elem_en,
    output logic                elem_zero,
    output logic                cr_write,
    output logic                fault_report,
    output logic                done,
    output logic [VLW-1:0]      vl_out
);
    seq_state_e     state_q, state_d;
    seq_mode_e      cfg_mode;
    logic           cfg_kind;
    logic [2:0]     cfg_sel;
    logic           cfg_zero;
    logic [1:0]     cfg_tsel;
    logic           cfg_inv;
    logic           cfg_rc;
    logic [VLW-1:0] cfg_vl;
    logic [IW-1:0]  idx_q;
    logic [VLW-1:0] vl_q;
    logic [VLW-1:0] vl_req;
    logic           pred_bit;
    logic           stop;
    logic           fault_rep;
    logic           last;
    logic           active;

    assign vl_req = (vl_in > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_in;
    assign last   = (VLW'(idx_q) == cfg_vl - VLW'(1));
    assign active = (state_q == ST_RUN);

    vec_pred_gen #(.XLEN(XLEN), .MAX_VL(MAX_VL), .IW(IW)) u_pred (
        .mask_kind (cfg_kind),
        .pred_sel  (cfg_sel),
        .idx       (idx_q),
        .r3        (r3),
        .r10       (r10),
        .r30       (r30),
        .pred_cr   (pred_cr),
        .pred_bit  (pred_bit)
    );

    vec_elem_decide u_decide (
        .active    (active),
        .mode      (cfg_mode),
        .pred_bit  (pred_bit),
        .res_cr    (res_cr),
        .test_sel  (cfg_tsel),
        .test_inv  (cfg_inv),
        .ld_fault  (ld_fault),
        .zero_en   (cfg_zero),
        .rc_en     (cfg_rc),
        .idx_zero  (idx_q == '0),
        .en        (elem_en),
        .zero      (elem_zero),
        .crw       (cr_write),
        .stop      (stop),
        .fault_rep (fault_rep)
    );

    // next state: GO, EMPTY, STEP, FINISH, CUT, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (vl_req == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (stop || last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        elem_valid   = (state_q == ST_RUN);
        done         = (state_q == ST_DONE);
        elem_idx     = idx_q;
        fault_report = fault_rep;
        vl_out       = vl_q;
    end

    // operation context and element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= MD_PLAIN;
            cfg_kind <= 1'b0;
            cfg_sel  <= '0;
            cfg_zero <= 1'b0;
            cfg_tsel <= '0;
            cfg_inv  <= 1'b0;
            cfg_rc   <= 1'b0;
            cfg_vl   <= '0;
            idx_q    <= '0;
            vl_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_mode <= seq_mode_e'(mode_sel);
                        cfg_kind <= mask_kind;
                        cfg_sel  <= pred_sel;
                        cfg_zero <= zero_en;
                        cfg_tsel <= test_sel;
                        cfg_inv  <= test_inv;
                        cfg_rc   <= rc_en;
                        cfg_vl   <= vl_req;
                        vl_q     <= vl_req;
                        idx_q    <= '0;
                    end
                end
                ST_RUN: begin
                    if (stop) begin
                        if (!fault_rep) vl_q <= VLW'(idx_q);
                    end else if (!last) begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk
    import vec_elem_seq_pkg::*;
#(
    parameter int MAX_VL = 16,
    localparam int VLW   = $clog2(MAX_VL + 1),
    localparam int IW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           elem_valid,
    input logic [IW-1:0]  elem_idx,
    input logic           elem_en,
    input logic           elem_zero,
    input logic           cr_write,
    input logic           fault_report,
    input logic           done,
    input logic [VLW-1:0] vl_out,
    input logic [VLW-1:0] cfg_vl,
    input seq_mode_e      cfg_mode
);

    AST_EN_ZERO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        elem_en |-> !elem_zero); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !elem_valid |-> (!elem_en && !elem_zero && !cr_write && !fault_report)); // R9

    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && $past(elem_valid)) |-> (elem_idx == IW'($past(elem_idx) + 1'b1))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fault_report |-> (elem_idx == '0)); // R7

    AST_LDFF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_mode == MD_LDFF && cfg_vl != '0) |-> (vl_out != '0)); // R7

    AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= cfg_vl)); // R5

endmodule

bind vec_elem_seq vec_elem_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .elem_valid   (elem_valid),
    .elem_idx     (elem_idx),
    .elem_en      (elem_en),
    .elem_zero    (elem_zero),
    .cr_write     (cr_write),
    .fault_report (fault_report),
    .done         (done),
    .vl_out       (vl_out),
    .cfg_vl       (cfg_vl),
    .cfg_mode     (cfg_mode)
);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;

    localparam int XLEN   = 64;
    localparam int MAX_VL = 16;
    localparam int VLW    = 5;
    localparam int IW     = 4;
    localparam int NV     = 22;

    typedef struct packed {
        logic [4:0]  vl;
        logic        mk;
        logic [2:0]  sel;
        logic        z;
        logic [1:0]  md;
        logic        inv;
        logic        rc;
        logic [15:0] r3;
        logic [15:0] r10;
        logic [15:0] r30;
        logic [63:0] pcr;
        logic [15:0] rpat;
        logic [15:0] fpat;
        logic [15:0] xen;
        logic [15:0] xzero;
        logic [15:0] xcrw;
        logic [4:0]  xvl;
        logic        xflt;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{5'd1,  1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 5'd1,  1'b0},
        '{5'd8,  1'b0, 3'd1, 1'b1, 2'd0, 1'b0, 1'b1, 16'h0005, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h0020, 16'h00DF, 16'h0020, 5'd8,  1'b0},
        '{5'd8,  1'b0, 3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 16'h00A5, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h00A5, 16'h0000, 16'h0000, 5'd8,  1'b0},
        '{5'd8,  1'b0, 3'd3, 1'b1, 2'd0, 1'b0, 1'b0, 16'h00A5, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h005A, 16'h00A5, 16'h0000, 5'd8,  1'b0},
        '{5'd16, 1'b0, 3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0F0F, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h0F0F, 16'h0000, 16'h0000, 5'd16, 1'b0},
        '{5'd12, 1'b0, 3'd7, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h00FF, 64'h0, 16'hFFFF, 16'h0000, 16'h0F00, 16'h00FF, 16'h0000, 5'd12, 1'b0},
        '{5'd16, 1'b1, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0808080808080808, 16'hFFFF, 16'h0000, 16'h5555, 16'h0000, 16'h0000, 5'd16, 1'b0},
        '{5'd8,  1'b1, 3'd5, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h2222, 16'hFFFF, 16'h0000, 16'h00F0, 16'h000F, 16'h0000, 5'd8,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'h00F7, 16'h0000, 16'h0007, 16'h0000, 16'h0007, 5'd3,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'h00FE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 5'd0,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'h0030, 16'h0000, 16'h000F, 16'h0000, 16'h0000, 5'd4,  1'b0},
        '{5'd8,  1'b0, 3'd2, 1'b0, 2'd1, 1'b0, 1'b0, 16'h00FB, 16'h0000, 16'h0000, 64'h0, 16'h00FB, 16'h0000, 16'h00FB, 16'h0000, 16'h0000, 5'd8,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0020, 16'h001F, 16'h0000, 16'h0000, 5'd5,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 5'd8,  1'b1},
        '{5'd8,  1'b0, 3'd2, 1'b1, 2'd3, 1'b0, 1'b1, 16'h0033, 16'h0000, 16'h0000, 64'h0, 16'h000F, 16'h0000, 16'h0003, 16'h00FC, 16'h0033, 5'd8,  1'b0},
        '{5'd8,  1'b0, 3'd2, 1'b0, 2'd3, 1'b0, 1'b0, 16'h0033, 16'h0000, 16'h0000, 64'h0, 16'h000F, 16'h0000, 16'h0003, 16'h0000, 16'h0000, 5'd8,  1'b0},
        '{5'd0,  1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 5'd0,  1'b0},
        '{5'd16, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 5'd16, 1'b0},
        '{5'd16, 1'b0, 3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0028, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 5'd16, 1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'h007F, 16'h0000, 16'h007F, 16'h0000, 16'h0000, 5'd7,  1'b0},
        '{5'd8,  1'b0, 3'd0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0080, 16'h007F, 16'h0000, 16'h0000, 5'd7,  1'b0},
        '{5'd8,  1'b0, 3'd2, 1'b0, 2'd2, 1'b0, 1'b0, 16'h00FD, 16'h0000, 16'h0000, 64'h0, 16'hFFFF, 16'h0002, 16'h00FD, 16'h0000, 16'h0000, 5'd8,  1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:              return "R10";
            1, 18:          return "R1";
            2, 3, 4, 5:     return "R2";
            6, 7:           return "R3";
            8, 10, 11, 19:  return "R5";
            9:              return "R6";
            12, 13, 20, 21: return "R7";
            14, 15:         return "R8";
            default:        return "R9";
        endcase
    endfunction

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [VLW-1:0]      vl_in = '0;
    logic                mask_kind = 1'b0;
    logic [2:0]          pred_sel = '0;
    logic                zero_en = 1'b0;
    logic [1:0]          mode_sel = '0;
    logic [1:0]          test_sel = 2'd2;
    logic                test_inv = 1'b0;
    logic                rc_en = 1'b0;
    logic [XLEN-1:0]     r3 = '0;
    logic [XLEN-1:0]     r10 = '0;
    logic [XLEN-1:0]     r30 = '0;
    logic [4*MAX_VL-1:0] pred_cr = '0;
    logic [3:0]          res_cr;
    logic                ld_fault;
    logic                elem_valid;
    logic [IW-1:0]       elem_idx;
    logic                elem_en;
    logic                elem_zero;
    logic                cr_write;
    logic                fault_report;
    logic                done;
    logic [VLW-1:0]      vl_out;

    logic [15:0] cur_rpat = 16'hFFFF;
    logic [15:0] cur_fpat = 16'h0000;
    logic        use_fixed = 1'b0;
    logic [3:0]  fixed_cr = 4'h0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always_comb begin
        res_cr   = use_fixed ? fixed_cr : {4{cur_rpat[elem_idx]}};
        ld_fault = cur_fpat[elem_idx];
    end

    vec_elem_seq #(.XLEN(XLEN), .MAX_VL(MAX_VL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .mask_kind(mask_kind), .pred_sel(pred_sel), .zero_en(zero_en),
        .mode_sel(mode_sel), .test_sel(test_sel), .test_inv(test_inv),
        .rc_en(rc_en), .r3(r3), .r10(r10), .r30(r30), .pred_cr(pred_cr),
        .res_cr(res_cr), .ld_fault(ld_fault), .elem_valid(elem_valid),
        .elem_idx(elem_idx), .elem_en(elem_en), .elem_zero(elem_zero),
        .cr_write(cr_write), .fault_report(fault_report), .done(done),
        .vl_out(vl_out)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    logic [15:0] got_en, got_zero, got_crw;
    logic        got_flt;
    int          got_cycles;

    task automatic run_op(input vec_t v, input logic [1:0] tsel);
        @(negedge clk);
        vl_in     = v.vl;
        mask_kind = v.mk;
        pred_sel  = v.sel;
        zero_en   = v.z;
        mode_sel  = v.md;
        test_inv  = v.inv;
        rc_en     = v.rc;
        test_sel  = tsel;
        r3        = {48'h0, v.r3};
        r10       = {48'h0, v.r10};
        r30       = {48'h0, v.r30};
        pred_cr   = v.pcr;
        cur_rpat  = v.rpat;
        cur_fpat  = v.fpat;
        start     = 1'b1;
        got_en = '0; got_zero = '0; got_crw = '0; got_flt = 1'b0;
        @(negedge clk);
        start = 1'b0;
        got_cycles = 1;
        while (!done && got_cycles < 100) begin
            if (elem_valid) begin
                got_en[elem_idx]   = elem_en;
                got_zero[elem_idx] = elem_zero;
                got_crw[elem_idx]  = cr_write;
                if (fault_report) got_flt = 1'b1;
            end
            @(negedge clk);
            got_cycles++;
        end
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "done", 32'(done), 32'd0);
        check("R11", "elem_valid", 32'(elem_valid), 32'd0);
        check("R11", "vl_out", 32'(vl_out), 32'd0);
        check("R11", "outputs", 32'({elem_en, elem_zero, cr_write, fault_report}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VT[i], 2'd2);
            check(tag_of(i), "elem_en mask", 32'(got_en), 32'(VT[i].xen));
            check((VT[i].xzero != 0) ? "R4" : tag_of(i), "elem_zero mask", 32'(got_zero), 32'(VT[i].xzero));
            check(tag_of(i), "cr_write mask", 32'(got_crw), 32'(VT[i].xcrw));
            check(tag_of(i), "vl_out", 32'(vl_out), 32'(VT[i].xvl));
            check(tag_of(i), "fault_report", 32'(got_flt), 32'(VT[i].xflt));
        end

        // R9 done timing for a full vector of 4: done VL+1 edges after start
        begin
            vec_t v;
            v = VT[17];
            v.vl = 5'd4;
            run_op(v, 2'd2);
            check("R9", "cycles to done (full)", 32'(got_cycles), 32'd5);
            @(negedge clk);
            check("R9", "done one cycle", 32'(done), 32'd0);
            check("R9", "idle after done", 32'(elem_valid), 32'd0);
        end

        // R5 truncation timing: failure on element 3 gives done 5 edges after start
        run_op(VT[8], 2'd2);
        check("R5", "cycles to done (cut)", 32'(got_cycles), 32'd5);

        // R9 empty vector
        run_op(VT[16], 2'd2);
        check("R9", "cycles to done (empty)", 32'(got_cycles), 32'd1);

        // R9 length clamp
        begin
            vec_t v;
            v = VT[17];
            v.vl = 5'd20;
            run_op(v, 2'd2);
            check("R9", "clamped vl_out", 32'(vl_out), 32'd16);
        end

        // R5/R6 test_sel picks the flag: field 0111 has LT clear, GT set
        use_fixed = 1'b1;
        fixed_cr  = 4'b0111;
        begin
            vec_t v;
            v = VT[8];
            v.vl = 5'd4;
            run_op(v, 2'd0);
            check("R6", "LT test vl_out", 32'(vl_out), 32'd0);
            check("R6", "LT test en", 32'(got_en), 32'd0);
            run_op(v, 2'd1);
            check("R5", "GT test vl_out", 32'(vl_out), 32'd4);
            check("R5", "GT test en", 32'(got_en), 32'h000F);
        end
        use_fixed = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule